// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Model

This block is a synthesizable behavioural model of a byte-wide programmable read-only memory. Voltage levels are reduced to digital flags. The control inputs are an active-low chip select, an active-low output gate, a flag for a raised program supply and a flag for a raised identifier voltage on one address line. The block decodes these into one of six operating modes. Depending on the mode, it drives the stored byte, drives one of two fixed identifier bytes, programs the addressed byte or keeps the bus idle. The bus is modelled as a data vector plus a drive-enable, not as a true tri-state.

Programming can only clear bits. A programmed cell holds the bitwise AND of its old value and the bus data. Only the erase input can return cells to ones. Erase sweeps the array one byte per clock and then raises a done flag. The address port is 20 bits wide. The number of bytes actually stored is set by a parameter, and the address bits above that range are ignored. The model is intended to be driven by a programmer sequence or a bus controller inside a testbench.

Top module: `otp_mem_model`

## Requirements
- R1: With chip select low, output gate low and the program flag low, `dataOe` is 1 and `dataOut` shows the byte stored at the address, with no clock edge needed.
- R2: With chip select low and output gate high (program flag low), `dataOe` is 0.
- R3: With chip select high, `dataOe` is 0 whatever the output gate, program flag and identifier flag are.
- R4: Each clock edge seen with chip select low and the program flag high replaces the addressed byte with (old AND `dataIn`), so a bit that is 0 never returns to 1 by programming.
- R5: With chip select high and the program flag high, no byte is changed and `dataOe` is 0.
- R6: A one-cycle `eraseReq` writes 8'hFF to every byte. `eraseDone` rises at the (DEPTH+1)-th rising edge counted from the edge that samples the request, and stays high until the next accepted request. DEPTH is 2**DEPTH_LOG2.
- R7: In read mode with `idHigh` = 1, `dataOut` is 8'h20 when address bit 0 is 0 and 8'h42 when it is 1, whatever the array holds.
- R8: Address bits at position DEPTH_LOG2 and above are ignored for both reads and programming.
- R9: While `dataOe` is 0, `dataOut` is 8'h00.
- R10: While an erase sweep runs, `dataOe` is 0, program cycles have no effect, and a further `eraseReq` is not accepted.
- R11: In program mode (chip select low, program flag high), `dataOe` is 0.
- R12: After reset, `eraseDone` is 0, no sweep is running and `dataOe` follows only the mode decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chipEnN | input | 1 | Active-low chip select |
| outEnN | input | 1 | Active-low output gate (read) |
| vppHigh | input | 1 | Program supply raised |
| idHigh | input | 1 | Identifier voltage present on the address line |
| addr | input | 20 | Byte address |
| dataIn | input | 8 | Data to program |
| eraseReq | input | 1 | Start an erase sweep |
| dataOut | output | 8 | Byte presented on the bus |
| dataOe | output | 1 | Bus drive enable |
| eraseDone | output | 1 | Erase sweep complete |

## Verification
The bound checker evaluates the following on every cycle:
- The bus is driven only when chip select and output gate are both low and the program flag is low.
- The bus is never driven during a sweep.
- `dataOut` is zero whenever the bus is idle.
- The identifier byte matches address bit 0.
- The done flag and the sweep never overlap, and the done flag falls only after a request.

Some behaviour only the directed scenarios can show:
- The AND-only programming result.
- The all-ones contents after a sweep.
- The exact sweep length.
- Address aliasing above the stored range.
- Program cycles during a sweep being discarded.

// File: rtl/otp_mem_pkg.sv
package otp_mem_pkg;

  localparam logic [7:0] ID_BYTE_LO = 8'h20;
  localparam logic [7:0] ID_BYTE_HI = 8'h42;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_OUTOFF,
    MODE_READ,
    MODE_IDREAD,
    MODE_PROGRAM,
    MODE_INHIBIT
  } memMode_e;

  typedef struct packed {
    logic wrEn;
    logic eraseWr;
    logic driveEn;
    logic idSel;
  } memStrobe_t;

endpackage

// File: rtl/otp_mem_ctrl.sv
module otp_mem_ctrl
  import otp_mem_pkg::*;
#(
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  chipEnN,
  input  logic                  outEnN,
  input  logic                  vppHigh,
  input  logic                  idHigh,
  input  logic                  eraseReq,
  output memStrobe_t            strb,
  output logic [DEPTH_LOG2-1:0] eraseAddr,
  output logic                  eraseDone
);

  memMode_e mode;
  logic     eraseBusy;
  logic     sweepLast;

  // Mode decode: the raised program supply overrides the output gate
  always_comb begin
    if (chipEnN)       mode = vppHigh ? MODE_INHIBIT : MODE_STANDBY;
    else if (vppHigh)  mode = MODE_PROGRAM;
    else if (outEnN)   mode = MODE_OUTOFF;
    else if (idHigh)   mode = MODE_IDREAD;
    else               mode = MODE_READ;
  end

  assign sweepLast = &eraseAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseBusy <= 1'b0;
      eraseAddr <= '0;
      eraseDone <= 1'b0;
    end else if (eraseBusy) begin
      eraseAddr <= eraseAddr + 1'b1;
      if (sweepLast) begin
        eraseBusy <= 1'b0;
        eraseDone <= 1'b1;
      end
    end else if (eraseReq) begin
      eraseBusy <= 1'b1;
      eraseAddr <= '0;
      eraseDone <= 1'b0;
    end
  end

  always_comb begin
    strb.eraseWr = eraseBusy;
    strb.wrEn    = (mode == MODE_PROGRAM) && !eraseBusy;
    strb.driveEn = ((mode == MODE_READ) || (mode == MODE_IDREAD)) && !eraseBusy;
    strb.idSel   = (mode == MODE_IDREAD);
  end

endmodule

// File: rtl/otp_mem_array.sv
module otp_mem_array
  import otp_mem_pkg::*;
#(
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                  clk,
  input  memStrobe_t            strb,
  input  logic [DEPTH_LOG2-1:0] cellAddr,
  input  logic [DEPTH_LOG2-1:0] eraseAddr,
  input  logic [7:0]            dataIn,
  output logic [7:0]            dataOut
);

  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.eraseWr)
      cells[eraseAddr] <= 8'hFF;
    else if (strb.wrEn)
      cells[cellAddr] <= cells[cellAddr] & dataIn;
  end

  always_comb begin
    if (!strb.driveEn)
      dataOut = 8'h00;
    else if (strb.idSel)
      dataOut = cellAddr[0] ? ID_BYTE_HI : ID_BYTE_LO;
    else
      dataOut = cells[cellAddr];
  end

endmodule

// File: rtl/otp_mem_model.sv
module otp_mem_model
  import otp_mem_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              vppHigh,
  input  logic              idHigh,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic              eraseReq,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output logic              eraseDone
);

  memStrobe_t            strb;
  logic [DEPTH_LOG2-1:0] eraseAddr;
  logic [DEPTH_LOG2-1:0] cellAddr;
  logic                  eraseBusy;
  logic                  unusedAddrHi;

  assign cellAddr     = addr[DEPTH_LOG2-1:0];
  assign unusedAddrHi = ^addr[ADDR_W-1:DEPTH_LOG2];
  assign eraseBusy    = strb.eraseWr;
  assign dataOe       = strb.driveEn;

  otp_mem_ctrl #(.DEPTH_LOG2(DEPTH_LOG2)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chipEnN   (chipEnN),
    .outEnN    (outEnN),
    .vppHigh   (vppHigh),
    .idHigh    (idHigh),
    .eraseReq  (eraseReq),
    .strb      (strb),
    .eraseAddr (eraseAddr),
    .eraseDone (eraseDone)
  );

  otp_mem_array #(.DEPTH_LOG2(DEPTH_LOG2)) u_array (
    .clk       (clk),
    .strb      (strb),
    .cellAddr  (cellAddr),
    .eraseAddr (eraseAddr),
    .dataIn    (dataIn),
    .dataOut   (dataOut)
  );

endmodule

// File: rtl/otp_mem_chk.sv
module otp_mem_chk (
  input logic       clk,
  input logic       rstN,
  input logic       chipEnN,
  input logic       outEnN,
  input logic       vppHigh,
  input logic       idHigh,
  input logic       addrBit0,
  input logic       eraseReq,
  input logic [7:0] dataOut,
  input logic       dataOe,
  input logic       eraseDone,
  input logic       eraseBusy
);

  // R1 R2 R3 R11
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (!chipEnN && !outEnN && !vppHigh));

  // R10
  no_drive_in_sweep_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseBusy |-> !dataOe);

  // R9
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == 8'h00));

  // R7
  id_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && idHigh) |-> (dataOut == (addrBit0 ? 8'h42 : 8'h20)));

  // R6
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(eraseDone && eraseBusy));

  // R6
  done_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eraseDone) |-> $past(eraseReq));

endmodule

bind otp_mem_model otp_mem_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .chipEnN   (chipEnN),
  .outEnN    (outEnN),
  .vppHigh   (vppHigh),
  .idHigh    (idHigh),
  .addrBit0  (addr[0]),
  .eraseReq  (eraseReq),
  .dataOut   (dataOut),
  .dataOe    (dataOe),
  .eraseDone (eraseDone),
  .eraseBusy (eraseBusy)
);

// File: tb/otp_mem_model_tb.sv
module otp_mem_model_tb;

  localparam int DL    = 6;
  localparam int DEPTH = 1 << DL;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipEnN = 1'b1, outEnN = 1'b1, vppHigh = 1'b0, idHigh = 1'b0;
  logic [19:0] addr = '0;
  logic [7:0]  dataIn = 8'hFF;
  logic        eraseReq = 1'b0;
  logic [7:0]  dataOut;
  logic        dataOe, eraseDone;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  otp_mem_model #(.ADDR_W(20), .DEPTH_LOG2(DL)) u_dut (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN),
    .vppHigh(vppHigh), .idHigh(idHigh), .addr(addr), .dataIn(dataIn),
    .eraseReq(eraseReq), .dataOut(dataOut), .dataOe(dataOe),
    .eraseDone(eraseDone)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setBus(logic e, logic g, logic v, logic id,
                        logic [19:0] a, logic [7:0] d);
    @(negedge clk);
    chipEnN = e; outEnN = g; vppHigh = v; idHigh = id; addr = a; dataIn = d;
    #1;
  endtask

  task automatic readByte(logic [19:0] a, output logic [7:0] v);
    setBus(1'b0, 1'b0, 1'b0, 1'b0, a, 8'hFF);
    v = dataOut;
  endtask

  task automatic progByte(logic [19:0] a, logic [7:0] d);
    setBus(1'b0, 1'b1, 1'b1, 1'b0, a, d);
    @(posedge clk);
    setBus(1'b1, 1'b1, 1'b0, 1'b0, a, 8'hFF);
  endtask

  task automatic testReset();
    check("R12 oe after reset", {7'd0, dataOe}, 8'h00);
    check("R12 done after reset", {7'd0, eraseDone}, 8'h00);
  endtask

  task automatic testErase();
    logic [7:0] v;
    @(negedge clk); eraseReq = 1'b1;
    @(negedge clk); eraseReq = 1'b0;
    for (int i = 0; i < DEPTH - 1; i++) @(negedge clk);
    check("R6 done not before DEPTH+1 edges", {7'd0, eraseDone}, 8'h00);
    @(negedge clk);
    check("R6 done at DEPTH+1 edges", {7'd0, eraseDone}, 8'h01);
    readByte(20'd0, v);  check("R6 R1 byte 0 erased", v, 8'hFF);
    check("R1 oe in read", {7'd0, dataOe}, 8'h01);
    readByte(20'd37, v); check("R6 byte 37 erased", v, 8'hFF);
    readByte(DEPTH - 1, v); check("R6 last byte erased", v, 8'hFF);
  endtask

  task automatic testProgram();
    logic [7:0] v;
    progByte(20'd5, 8'hA5);
    readByte(20'd5, v); check("R4 R1 program A5", v, 8'hA5);
    progByte(20'd5, 8'h5A);
    readByte(20'd5, v); check("R4 AND to zero", v, 8'h00);
    progByte(20'd6, 8'hF0);
    progByte(20'd6, 8'h3C);
    readByte(20'd6, v); check("R4 AND F0 3C", v, 8'h30);
    progByte(20'd6, 8'hFF);
    readByte(20'd6, v); check("R4 no bit back to 1", v, 8'h30);
    readByte(20'd7, v); check("R4 neighbour untouched", v, 8'hFF);
  endtask

  task automatic testOutputs();
    logic [7:0] v;
    setBus(1'b0, 1'b1, 1'b0, 1'b0, 20'd5, 8'hFF);
    check("R2 gate high no drive", {7'd0, dataOe}, 8'h00);
    check("R9 idle bus zero", dataOut, 8'h00);
    setBus(1'b1, 1'b0, 1'b0, 1'b0, 20'd7, 8'hFF);
    check("R3 standby no drive", {7'd0, dataOe}, 8'h00);
    setBus(1'b1, 1'b0, 1'b0, 1'b1, 20'd1, 8'hFF);
    check("R3 standby with id flag", {7'd0, dataOe}, 8'h00);
    setBus(1'b0, 1'b0, 1'b1, 1'b0, 20'd9, 8'hFF);
    check("R11 program mode no drive", {7'd0, dataOe}, 8'h00);
    setBus(1'b1, 1'b0, 1'b1, 1'b0, 20'd7, 8'h00);
    check("R5 inhibit no drive", {7'd0, dataOe}, 8'h00);
    @(posedge clk);
    readByte(20'd7, v); check("R5 inhibit leaves byte", v, 8'hFF);
  endtask

  task automatic testId();
    setBus(1'b0, 1'b0, 1'b0, 1'b1, 20'd0, 8'hFF);
    check("R7 id low byte", dataOut, 8'h20);
    setBus(1'b0, 1'b0, 1'b0, 1'b1, 20'd1, 8'hFF);
    check("R7 id high byte", dataOut, 8'h42);
    setBus(1'b0, 1'b1, 1'b0, 1'b1, 20'd1, 8'hFF);
    check("R7 R2 id gated off", {7'd0, dataOe}, 8'h00);
  endtask

  task automatic testAlias();
    logic [7:0] v;
    readByte(20'h80005, v); check("R8 read alias of 5", v, 8'h00);
    progByte(20'h40008, 8'h81);
    readByte(20'd8, v); check("R8 program via alias", v, 8'h81);
  endtask

  task automatic testSweepBusy();
    logic [7:0] v;
    @(negedge clk); eraseReq = 1'b1;
    @(negedge clk); eraseReq = 1'b0;
    check("R6 done cleared on request", {7'd0, eraseDone}, 8'h00);
    for (int i = 0; i < 8; i++) @(negedge clk);
    setBus(1'b0, 1'b0, 1'b0, 1'b0, 20'd3, 8'hFF);
    check("R10 no drive in sweep", {7'd0, dataOe}, 8'h00);
    progByte(20'd0, 8'h00);
    @(negedge clk); eraseReq = 1'b1;
    @(negedge clk); eraseReq = 1'b0;
    while (!eraseDone) @(negedge clk);
    readByte(20'd0, v); check("R10 program in sweep ignored", v, 8'hFF);
    readByte(20'd5, v); check("R6 re-erase byte 5", v, 8'hFF);
    readByte(20'd8, v); check("R6 re-erase byte 8", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testErase();
    testProgram();
    testOutputs();
    testId();
    testAlias();
    testSweepBusy();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule